// File: doc/BRIEF.md
# Cartridge PRG Bank Mapper

This block controls banking on the cartridge side of an 8-bit console CPU bus. The CPU writes to a window of registers at $5000–$5FFF. Only the upper address byte selects a register, so every address in a 256-byte page reaches the same register. From the stored bank fields and the mode bit, the block forms PRG-ROM address lines A20..A14 for CPU accesses to $8000–$FFFF. It raises a PRG-RAM enable for $6000–$7FFF and drives a nametable mirroring selection.

There are two PRG layouts. The first is a 16 KiB switchable window at $8000 with a semi-fixed upper window. That upper window holds bank 31, or bank 28 or 30 when an alternate-top bit is set. The second is a single 32 KiB switchable window. A separate register adds two outer bank bits in both layouts. Mirroring is forced to vertical in the 16 KiB layout and is selectable in the 32 KiB layout.

The block also provides a bit-banged serial EEPROM port: two chip selects, a clock and a data-out line, all taken from one register. The incoming data line can be read back inverted. The PRG-ROM address is combinational from CPU A14 and the registers, so it is valid in the same bus cycle.

Top module: `prg_bank_ctrl`

## Requirements
- R1: After synchronous reset every register is zero. An access at $C000 then gives PRG A20..A14 = 7'h1F, an access at $8000 gives 7'h00, mirror_vert is 1, and all four EEPROM outputs are 0.
- R2: A register is selected by cpu_addr[15:8] alone: page $50 is the low bank/mode register, $51 the outer bank register, $52 the serial output register, $53 the mirroring register and $55 the serial readback. The low address byte has no effect. Writes to any other page in $5000–$5FFF change nothing.
- R3: In the low register, bit 4 is the mode bit M, bit 5 is Q, bit 6 is the alternate-top bit S, and bits 3..0 form the bank field B (bit 0 is p). With M=0 and CPU A14=0, PRG A18..A14 = {Q, B[3:0]}.
- R4: With M=0, CPU A14=1 and S=0, PRG A18..A14 = 5'b11111.
- R5: With M=0, CPU A14=1 and S=1, PRG A18..A14 = {3'b111, p, 1'b0}.
- R6: With M=1, PRG A14 equals CPU A14 and PRG A18..A15 = B[3:0]. Q and S have no effect in this mode.
- R7: Bits 1..0 of the page-$51 register drive PRG A20..A19 in both modes.
- R8: mirror_vert is 1 (vertical) whenever M=0. With M=1 it equals bit 7 of the page-$53 register (0 = horizontal, 1 = vertical).
- R9: A write to page $52 sets ee_do from bit 0, ee_clk from bit 2, ee_cs1 from bit 4 and ee_cs2 from bit 6. The outputs hold until the next such write.
- R10: A CPU read (cpu_rw=1, m2=1) of page $55 asserts cpu_rdata_oe, and cpu_rdata has bit 2 = ~ee_di with all other bits 0. cpu_rdata_oe is 0 for any other access.
- R11: prg_ram_ce is 1 exactly for $6000–$7FFF, and ram_addr = cpu_addr[10:0], so a 2 KiB RAM appears four times. prg_rom_ce is 1 exactly for $8000–$FFFF.
- R12: A register is written only on a clock edge where m2=1 and cpu_rw=0. A cycle with m2=0, or a read cycle, leaves every register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU address bus |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rw | input | 1 | 1 = read, 0 = write |
| m2 | input | 1 | CPU bus phase, high during valid data |
| cpu_rdata | output | 8 | Readback data for page $55 |
| cpu_rdata_oe | output | 1 | Drive enable for cpu_rdata |
| prg_bank | output | 7 | PRG-ROM address bits A20..A14 |
| prg_rom_ce | output | 1 | PRG-ROM select for $8000–$FFFF |
| prg_ram_ce | output | 1 | PRG-RAM select for $6000–$7FFF |
| ram_addr | output | 11 | PRG-RAM address |
| mirror_vert | output | 1 | 1 = vertical, 0 = horizontal mirroring |
| ee_cs1 | output | 1 | EEPROM 1 chip select |
| ee_cs2 | output | 1 | EEPROM 2 chip select |
| ee_clk | output | 1 | EEPROM serial clock |
| ee_do | output | 1 | EEPROM serial data out |
| ee_di | input | 1 | EEPROM serial data in |

## Verification
The bench uses both settings of the alternate-top bit with both values of p. If that path were wrong, the upper window would sit on bank 31 or on the wrong one of banks 28 and 30.

It changes Q while the 32 KiB mode is active. A design that still honoured Q, or that ignored CPU A14, would return a wrong bank.

It sets the mirroring register and then returns to the 16 KiB mode. A design that did not force vertical mirroring there would show horizontal.

It writes with m2 low, issues read cycles, writes to unused pages, and uses nonzero low address bytes. Any of these would change a register in a design with loose decode or strobe handling.

// File: rtl/prgmap_pkg.sv
package prgmap_pkg;

    localparam int CPU_AW   = 16;
    localparam int DATA_W   = 8;
    localparam int INNER_W  = 5;
    localparam int OUTER_W  = 2;
    localparam int BANK_W   = INNER_W + OUTER_W;
    localparam int RAM_AW   = 11;
    localparam int PAGE_W   = 8;

    // low register fields, bits 6..0 (bit 7 belongs to CHR logic outside this block)
    typedef struct packed {
        logic       alt_top;   // bit 6
        logic       q_hi;      // bit 5
        logic       wide_mode; // bit 4
        logic [3:0] sel;       // bits 3..0
    } low_reg_t;

    typedef struct packed {
        logic cs2;
        logic cs1;
        logic sclk;
        logic sdo;
    } ser_reg_t;

    typedef enum logic [2:0] {
        PG_LOW  = 3'd0,
        PG_HIGH = 3'd1,
        PG_SER  = 3'd2,
        PG_MIR  = 3'd3,
        PG_RD   = 3'd4,
        PG_NONE = 3'd7
    } page_e;

    typedef enum logic {
        MIR_HORZ = 1'b0,
        MIR_VERT = 1'b1
    } mirror_e;

    function automatic page_e decode_page(input logic [PAGE_W-1:0] hi);
        case (hi)
            8'h50:   return PG_LOW;
            8'h51:   return PG_HIGH;
            8'h52:   return PG_SER;
            8'h53:   return PG_MIR;
            8'h55:   return PG_RD;
            default: return PG_NONE;
        endcase
    endfunction

    // inner 16 KiB bank number (PRG A18..A14)
    function automatic logic [INNER_W-1:0] inner_bank(input low_reg_t r, input logic a14);
        logic [INNER_W-1:0] b;
        if (r.wide_mode)
            b = {r.sel, a14};
        else if (!a14)
            b = {r.q_hi, r.sel};
        else if (r.alt_top)
            b = {3'b111, r.sel[0], 1'b0};
        else
            b = '1;
        return b;
    endfunction

endpackage

// File: rtl/prgmap_regs.sv
module prgmap_regs
    import prgmap_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  page_e               page,
    input  logic [DATA_W-1:0]   wdata,
    output low_reg_t            low_q,
    output logic [OUTER_W-1:0]  outer_q,
    output logic                mir_q,
    output ser_reg_t            ser_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            low_q   <= '0;
            outer_q <= '0;
            mir_q   <= 1'b0;
            ser_q   <= '0;
        end else if (wr_en) begin
            case (page)
                PG_LOW:  low_q   <= low_reg_t'(wdata[6:0]);
                PG_HIGH: outer_q <= wdata[OUTER_W-1:0];
                PG_SER:  ser_q   <= '{cs2: wdata[6], cs1: wdata[4], sclk: wdata[2], sdo: wdata[0]};
                PG_MIR:  mir_q   <= wdata[7];
                default: ;
            endcase
        end
    end

    // R12: no strobe, no change
    a_r12_hold_without_strobe: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> ($stable(low_q) && $stable(outer_q) && $stable(mir_q) && $stable(ser_q)));

    // R7: outer register takes the written bits
    a_r7_outer_capture: assert property (@(posedge clk) disable iff (rst)
        (wr_en && page == PG_HIGH) |=> (outer_q == $past(wdata[1:0])));

    // R2: unused pages leave all state alone
    a_r2_unused_page: assert property (@(posedge clk) disable iff (rst)
        (page == PG_NONE || page == PG_RD) |=> ($stable(low_q) && $stable(outer_q) && $stable(mir_q) && $stable(ser_q)));

endmodule

// File: rtl/prgmap_xlate.sv
module prgmap_xlate
    import prgmap_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  low_reg_t            low_q,
    input  logic [OUTER_W-1:0]  outer_q,
    input  logic                mir_q,
    input  logic                a14,
    output logic [BANK_W-1:0]   bank,
    output mirror_e             mirror
);

    logic [INNER_W-1:0] inner;

    always_comb begin
        inner  = inner_bank(low_q, a14);
        bank   = {outer_q, inner};
        mirror = low_q.wide_mode ? mirror_e'(mir_q) : MIR_VERT;
    end

    // R4: fixed top window
    a_r4_fixed_top: assert property (@(posedge clk) disable iff (rst)
        (!low_q.wide_mode && a14 && !low_q.alt_top) |-> (bank[INNER_W-1:0] == 5'h1F));

    // R5: alternate top window is 28 or 30
    a_r5_alt_top: assert property (@(posedge clk) disable iff (rst)
        (!low_q.wide_mode && a14 && low_q.alt_top) |-> (bank[4:2] == 3'b111 && !bank[0]));

    // R6: 32 KiB mode passes A14 through
    a_r6_wide_a14: assert property (@(posedge clk) disable iff (rst)
        low_q.wide_mode |-> (bank[0] == a14));

    // R8: vertical forced in 16 KiB mode
    a_r8_forced_vert: assert property (@(posedge clk) disable iff (rst)
        !low_q.wide_mode |-> (mirror == MIR_VERT));

    // R7: outer bits on top in every mode
    a_r7_outer_bits: assert property (@(posedge clk) disable iff (rst)
        bank[BANK_W-1:INNER_W] == outer_q);

endmodule

// File: rtl/prgmap_serial.sv
module prgmap_serial
    import prgmap_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  ser_reg_t           ser_q,
    input  logic               rd_hit,
    input  logic               ee_di,
    output logic               ee_cs1,
    output logic               ee_cs2,
    output logic               ee_clk,
    output logic               ee_do,
    output logic [DATA_W-1:0]  rdata,
    output logic               rdata_oe
);

    localparam int DI_BIT = 2;

    always_comb begin
        ee_cs1   = ser_q.cs1;
        ee_cs2   = ser_q.cs2;
        ee_clk   = ser_q.sclk;
        ee_do    = ser_q.sdo;
        rdata    = '0;
        rdata[DI_BIT] = ~ee_di;
        rdata_oe = rd_hit;
    end

    // R10: only bit 2 may be set in readback
    a_r10_readback_bits: assert property (@(posedge clk) disable iff (rst)
        rdata_oe |-> ($countones(rdata) <= 1 && rdata[DI_BIT] != ee_di));

endmodule

// File: rtl/prg_bank_ctrl.sv
module prg_bank_ctrl
    import prgmap_pkg::*;
#(
    parameter int AW      = CPU_AW,
    parameter int DW      = DATA_W,
    parameter int BW      = BANK_W,
    parameter int RAM_W   = RAM_AW
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [AW-1:0]   cpu_addr,
    input  logic [DW-1:0]   cpu_wdata,
    input  logic            cpu_rw,
    input  logic            m2,
    output logic [DW-1:0]   cpu_rdata,
    output logic            cpu_rdata_oe,
    output logic [BW-1:0]   prg_bank,
    output logic            prg_rom_ce,
    output logic            prg_ram_ce,
    output logic [RAM_W-1:0] ram_addr,
    output logic            mirror_vert,
    output logic            ee_cs1,
    output logic            ee_cs2,
    output logic            ee_clk,
    output logic            ee_do,
    input  logic            ee_di
);

    localparam int A14_BIT = 14;

    page_e              page;
    logic               wr_en;
    logic               rd_hit;
    low_reg_t           low_q;
    logic [OUTER_W-1:0] outer_q;
    logic               mir_q;
    ser_reg_t           ser_q;
    mirror_e            mirror;

    always_comb begin
        page       = decode_page(cpu_addr[AW-1:AW-PAGE_W]);
        wr_en      = m2 && !cpu_rw;
        rd_hit     = m2 && cpu_rw && (page == PG_RD);
        prg_rom_ce = cpu_addr[AW-1];
        prg_ram_ce = (cpu_addr[AW-1:AW-3] == 3'b011);
        ram_addr   = cpu_addr[RAM_W-1:0];
        mirror_vert = (mirror == MIR_VERT);
    end

    prgmap_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .page    (page),
        .wdata   (cpu_wdata),
        .low_q   (low_q),
        .outer_q (outer_q),
        .mir_q   (mir_q),
        .ser_q   (ser_q)
    );

    prgmap_xlate u_xlate (
        .clk     (clk),
        .rst     (rst),
        .low_q   (low_q),
        .outer_q (outer_q),
        .mir_q   (mir_q),
        .a14     (cpu_addr[A14_BIT]),
        .bank    (prg_bank),
        .mirror  (mirror)
    );

    prgmap_serial u_serial (
        .clk      (clk),
        .rst      (rst),
        .ser_q    (ser_q),
        .rd_hit   (rd_hit),
        .ee_di    (ee_di),
        .ee_cs1   (ee_cs1),
        .ee_cs2   (ee_cs2),
        .ee_clk   (ee_clk),
        .ee_do    (ee_do),
        .rdata    (cpu_rdata),
        .rdata_oe (cpu_rdata_oe)
    );

    // R11: RAM and ROM selects never overlap
    a_r11_ce_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(prg_ram_ce && prg_rom_ce));

    // R10: readback driven only on reads
    a_r10_oe_on_read: assert property (@(posedge clk) disable iff (rst)
        cpu_rdata_oe |-> (cpu_rw && m2));

endmodule

// File: tb/test_prg_bank_ctrl.sv
module test_prg_bank_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cpu_addr = 16'h0000;
    logic [7:0]  cpu_wdata = 8'h00;
    logic        cpu_rw = 1'b1;
    logic        m2 = 1'b0;
    logic [7:0]  cpu_rdata;
    logic        cpu_rdata_oe;
    logic [6:0]  prg_bank;
    logic        prg_rom_ce, prg_ram_ce;
    logic [10:0] ram_addr;
    logic        mirror_vert;
    logic        ee_cs1, ee_cs2, ee_clk, ee_do;
    logic        ee_di = 1'b0;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    prg_bank_ctrl i_prg_bank_ctrl (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rw(cpu_rw), .m2(m2), .cpu_rdata(cpu_rdata), .cpu_rdata_oe(cpu_rdata_oe),
        .prg_bank(prg_bank), .prg_rom_ce(prg_rom_ce), .prg_ram_ce(prg_ram_ce),
        .ram_addr(ram_addr), .mirror_vert(mirror_vert), .ee_cs1(ee_cs1),
        .ee_cs2(ee_cs2), .ee_clk(ee_clk), .ee_do(ee_do), .ee_di(ee_di)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // one bus cycle; registers capture at the rising edge inside it
    task automatic bus(input logic [15:0] a, input logic [7:0] d, input logic rw, input logic m);
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; cpu_rw = rw; m2 = m;
        @(negedge clk);
        m2 = 1'b0; cpu_rw = 1'b1;
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        bus(a, d, 1'b0, 1'b1);
    endtask

    task automatic look(input logic [15:0] a);
        cpu_addr = a;
        #1;
    endtask

    task automatic t_reset;
        look(16'hC000); chk("R1", "bank@C000", prg_bank, 7'h1F);
        look(16'h8000); chk("R1", "bank@8000", prg_bank, 7'h00);
        chk("R1", "mirror", mirror_vert, 1'b1);
        chk("R1", "ee outs", {ee_cs2, ee_cs1, ee_clk, ee_do}, 4'h0);
    endtask

    task automatic t_ux_switch;
        wr(16'h50A7, 8'h2B);                 // Q=1, M=0, B=1011, low byte nonzero (R2)
        look(16'h8123); chk("R3", "ux low window", prg_bank, 7'h1B);
        look(16'hFFFC); chk("R4", "fixed top", prg_bank, 7'h1F);
        chk("R2", "low byte ignored", prg_bank[4:0], 5'h1F);
    endtask

    task automatic t_alt_top;
        wr(16'h5000, 8'h41);
        look(16'hC000); chk("R5", "alt top p=1", prg_bank, 7'h1E);
        look(16'h8000); chk("R5", "low with S", prg_bank, 7'h01);
        wr(16'h50FF, 8'h40);
        look(16'hE000); chk("R5", "alt top p=0", prg_bank, 7'h1C);
    endtask

    task automatic t_wide;
        wr(16'h5000, 8'h1A);
        look(16'h8000); chk("R6", "wide lower", prg_bank, 7'h14);
        look(16'hC000); chk("R6", "wide upper", prg_bank, 7'h15);
        wr(16'h5000, 8'h7A);                 // Q and S set, no effect
        look(16'h8000); chk("R6", "Q/S ignored lower", prg_bank, 7'h14);
        look(16'hC000); chk("R6", "Q/S ignored upper", prg_bank, 7'h15);
    endtask

    task automatic t_outer;
        wr(16'h51FF, 8'h03);
        wr(16'h5000, 8'h1A);
        look(16'hC000); chk("R7", "outer wide", prg_bank, 7'h75);
        wr(16'h5000, 8'h05);
        look(16'h8000); chk("R7", "outer ux low", prg_bank, 7'h65);
        look(16'hC000); chk("R7", "outer ux top", prg_bank, 7'h7F);
        wr(16'h5100, 8'hFE);
        look(16'hC000); chk("R7", "outer only 2 bits", prg_bank, 7'h5F);
        wr(16'h5100, 8'h00);
    endtask

    task automatic t_mirror;
        wr(16'h5300, 8'h80);
        wr(16'h5000, 8'h00);
        chk("R8", "forced vert M=0", mirror_vert, 1'b1);
        wr(16'h5000, 8'h10);
        chk("R8", "sel vert", mirror_vert, 1'b1);
        wr(16'h5344, 8'h7F);
        chk("R8", "sel horz", mirror_vert, 1'b0);
        wr(16'h5000, 8'h00);
        chk("R8", "forced vert again", mirror_vert, 1'b1);
    endtask

    task automatic t_serial;
        wr(16'h5200, 8'h55);
        chk("R9", "all high", {ee_cs2, ee_cs1, ee_clk, ee_do}, 4'hF);
        wr(16'h5201, 8'h14);
        chk("R9", "cs1+clk", {ee_cs2, ee_cs1, ee_clk, ee_do}, 4'b0110);
        wr(16'h5200, 8'h41);
        chk("R9", "cs2+do", {ee_cs2, ee_cs1, ee_clk, ee_do}, 4'b1001);
        wr(16'h5200, 8'hAA);
        chk("R9", "odd bits none", {ee_cs2, ee_cs1, ee_clk, ee_do}, 4'h0);
    endtask

    task automatic t_readback;
        @(negedge clk);
        ee_di = 1'b0; cpu_addr = 16'h5512; cpu_rw = 1'b1; m2 = 1'b1;
        #1;
        chk("R10", "oe on read", cpu_rdata_oe, 1'b1);
        chk("R10", "data di=0", cpu_rdata, 8'h04);
        ee_di = 1'b1; #1;
        chk("R10", "data di=1", cpu_rdata, 8'h00);
        cpu_addr = 16'h5400; #1;
        chk("R10", "oe other page", cpu_rdata_oe, 1'b0);
        cpu_addr = 16'h5500; cpu_rw = 1'b0; #1;
        chk("R10", "oe on write", cpu_rdata_oe, 1'b0);
        cpu_rw = 1'b1; m2 = 1'b0; #1;
        chk("R10", "oe m2 low", cpu_rdata_oe, 1'b0);
        ee_di = 1'b0;
    endtask

    task automatic t_ram;
        look(16'h6000); chk("R11", "ram ce 6000", {prg_ram_ce, prg_rom_ce}, 2'b10);
        look(16'h7FFF); chk("R11", "ram ce 7FFF", prg_ram_ce, 1'b1);
        chk("R11", "ram addr 7FFF", ram_addr, 11'h7FF);
        look(16'h6800); chk("R11", "ram mirror", ram_addr, 11'h000);
        look(16'h5FFF); chk("R11", "below window", {prg_ram_ce, prg_rom_ce}, 2'b00);
        look(16'h8000); chk("R11", "rom ce", {prg_ram_ce, prg_rom_ce}, 2'b01);
    endtask

    task automatic t_ignore;
        wr(16'h5000, 8'h03);                 // reference state: bank 3 low
        wr(16'h5200, 8'h00);
        bus(16'h5000, 8'h1F, 1'b0, 1'b0);    // m2 low
        look(16'h8000); chk("R12", "m2 low write", prg_bank, 7'h03);
        bus(16'h5000, 8'h1F, 1'b1, 1'b1);    // read cycle
        look(16'h8000); chk("R12", "read cycle", prg_bank, 7'h03);
        bus(16'h5200, 8'h55, 1'b1, 1'b1);
        chk("R12", "read to serial", {ee_cs2, ee_cs1, ee_clk, ee_do}, 4'h0);
        wr(16'h5400, 8'hFF);
        wr(16'h5A52, 8'hFF);
        wr(16'h5550, 8'hFF);
        look(16'h8000); chk("R2", "unused pages bank", prg_bank, 7'h03);
        chk("R2", "unused pages serial", {ee_cs2, ee_cs1, ee_clk, ee_do}, 4'h0);
        chk("R2", "unused pages mirror", mirror_vert, 1'b1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_ux_switch();
        t_alt_top();
        t_wide();
        t_outer();
        t_mirror();
        t_serial();
        t_readback();
        t_ram();
        t_ignore();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule